// File: doc/BRIEF.md
# Bus Address Latch and Device Select Decoder

This block sits beside a processor whose bus shares its low sixteen address bits with the data pins. At the start of every bus cycle, the processor raises an address strobe. On that cycle the block captures the twenty-bit address and the memory/port type of the cycle. The lower sixteen bits come from the shared lines and the upper four from dedicated lines. The captured value stays on the latched-address output until the next strobe. After the strobe the shared lines are free to carry data.

The block decodes the captured address into one of four device selects:
- main RAM
- a peripheral window mapped into memory space
- boot ROM
- a bank of I/O ports

Memory space and port space are kept strictly apart. A memory device is never selected on a port cycle, and the port device is never selected on a memory cycle, even when the numeric addresses match. A select is driven only while a read or write strobe is active. When an access hits no device, an error flag is raised instead for as long as the strobe lasts.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `bus_addr_decode`

## Requirements
- R1: On a rising clock edge with `ale_i` high, `lat_addr_o` takes the value {`a_hi_i`, `ad_i`}, and the cycle type is taken from `mio_i` (1 = memory, 0 = I/O port).
- R2: While `ale_i` stays low, `lat_addr_o` and the captured type keep their values, whatever the shared lines carry.
- R3: While reset is active, `lat_addr_o` is zero and every select and the error flag are low. After reset, nothing is driven until the first address strobe.
- R4: On a memory cycle with the latched address in 0x00000..0x9FFFF, `cs_ram_o` is high.
- R5: On a memory cycle with the latched address in 0xA0000..0xBFFFF, `cs_mmio_o` is high.
- R6: On a memory cycle with the latched address in 0xF0000..0xFFFFF, `cs_rom_o` is high.
- R7: On a memory cycle with the latched address in 0xC0000..0xEFFFF, `nodec_o` is high and no select is driven.
- R8: On an I/O cycle, only latched bits 15:0 are decoded. A port address in 0x0000..0x00FF drives `cs_port_o` high, whatever the upper bits are.
- R9: On an I/O cycle with a port address of 0x0100 or above, `nodec_o` is high and no select is driven.
- R10: A memory select is never high on an I/O cycle, and `cs_port_o` is never high on a memory cycle, even at the same numeric address.
- R11: With both `rd_i` and `wr_i` low, every select and `nodec_o` are low. A read strobe and a write strobe decode alike.
- R12: At most one of the four selects and `nodec_o` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ad_i | input | 16 | Shared address/data lines, carrying address bits 15:0 during the strobe |
| a_hi_i | input | 4 | Dedicated address bits 19:16 |
| ale_i | input | 1 | Address strobe, high in the first clock state of a cycle |
| mio_i | input | 1 | Cycle type: 1 memory, 0 I/O port |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| lat_addr_o | output | 20 | Latched address |
| cs_ram_o | output | 1 | RAM select |
| cs_mmio_o | output | 1 | Memory-mapped peripheral window select |
| cs_rom_o | output | 1 | ROM select |
| cs_port_o | output | 1 | I/O port device select |
| nodec_o | output | 1 | No device decoded for the current access |

## Verification
The latched address and the captured type are due one rising edge after the strobe, so each scenario drives the strobe at a falling edge and reads `lat_addr_o` at the next falling edge. The selects and the error flag are combinational from the latched state and the live strobes. They are sampled one time unit after the read or write strobe changes, once with the strobe high and again after it drops. The hold checks change the shared lines between strobes and read the latch back half a cycle after the following edge.

// File: rtl/bus_addr_pkg.sv
package bus_addr_pkg;
  // Decoded target of one bus access
  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_RAM  = 3'd1,
    TGT_MMIO = 3'd2,
    TGT_ROM  = 3'd3,
    TGT_PORT = 3'd4
  } tgt_e;

  // Memory hits from the memory decoder
  typedef struct packed {
    logic ram;
    logic mmio;
    logic rom;
  } mem_hit_t;
endpackage

// File: rtl/addr_capture.sv
module addr_capture #(
  parameter int ADDR_W = 20,
  parameter int AD_W   = 16,
  localparam int HI_W  = ADDR_W - AD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_i,
  input  logic [AD_W-1:0]   ad_i,
  input  logic [HI_W-1:0]   a_hi_i,
  input  logic              mio_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              is_mem_o,
  output logic              armed_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      is_mem_o <= 1'b0;
      armed_o  <= 1'b0;
    end else if (ale_i) begin
      addr_o   <= {a_hi_i, ad_i};
      is_mem_o <= mio_i;
      armed_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/mem_region_dec.sv
module mem_region_dec
  import bus_addr_pkg::*;
#(
  parameter int ADDR_W                 = 20,
  parameter logic [ADDR_W-1:0] RAM_END  = 20'h9FFFF,
  parameter logic [ADDR_W-1:0] MMIO_BEG = 20'hA0000,
  parameter logic [ADDR_W-1:0] MMIO_END = 20'hBFFFF,
  parameter logic [ADDR_W-1:0] ROM_BEG  = 20'hF0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output mem_hit_t          hit_o
);
  always_comb begin
    hit_o      = '0;
    hit_o.ram  = (addr_i <= RAM_END);
    hit_o.mmio = (addr_i >= MMIO_BEG) && (addr_i <= MMIO_END);
    hit_o.rom  = (addr_i >= ROM_BEG);
  end
endmodule

// File: rtl/port_region_dec.sv
module port_region_dec #(
  parameter int PORT_W                  = 16,
  parameter int DEV_BITS                = 8,
  localparam int UPPER_W                = PORT_W - DEV_BITS
) (
  input  logic [PORT_W-1:0] port_i,
  output logic              hit_o
);
  // Port device owns every port whose bits above DEV_BITS are zero
  generate
    if (UPPER_W > 0) begin : g_upper
      assign hit_o = (port_i[PORT_W-1:DEV_BITS] == '0);
    end else begin : g_full
      assign hit_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/bus_addr_decode.sv
module bus_addr_decode
  import bus_addr_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int AD_W     = 16,
  parameter int PORT_W   = 16,
  parameter int DEV_BITS = 8,
  localparam int HI_W    = ADDR_W - AD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AD_W-1:0]   ad_i,
  input  logic [HI_W-1:0]   a_hi_i,
  input  logic              ale_i,
  input  logic              mio_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [ADDR_W-1:0] lat_addr_o,
  output logic              cs_ram_o,
  output logic              cs_mmio_o,
  output logic              cs_rom_o,
  output logic              cs_port_o,
  output logic              nodec_o
);
  logic     lat_mem;
  logic     armed;
  mem_hit_t mhit;
  logic     phit;
  logic     strobe;
  tgt_e     tgt;

  addr_capture #(.ADDR_W(ADDR_W), .AD_W(AD_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ale_i    (ale_i),
    .ad_i     (ad_i),
    .a_hi_i   (a_hi_i),
    .mio_i    (mio_i),
    .addr_o   (lat_addr_o),
    .is_mem_o (lat_mem),
    .armed_o  (armed)
  );

  mem_region_dec #(.ADDR_W(ADDR_W)) u_mdec (
    .addr_i (lat_addr_o),
    .hit_o  (mhit)
  );

  port_region_dec #(.PORT_W(PORT_W), .DEV_BITS(DEV_BITS)) u_pdec (
    .port_i (lat_addr_o[PORT_W-1:0]),
    .hit_o  (phit)
  );

  assign strobe = (rd_i | wr_i) & armed;

  always_comb begin
    tgt = TGT_NONE;
    if (lat_mem) begin
      if (mhit.ram)       tgt = TGT_RAM;
      else if (mhit.mmio) tgt = TGT_MMIO;
      else if (mhit.rom)  tgt = TGT_ROM;
    end else if (phit) begin
      tgt = TGT_PORT;
    end
  end

  assign cs_ram_o  = strobe && (tgt == TGT_RAM);
  assign cs_mmio_o = strobe && (tgt == TGT_MMIO);
  assign cs_rom_o  = strobe && (tgt == TGT_ROM);
  assign cs_port_o = strobe && (tgt == TGT_PORT);
  assign nodec_o   = strobe && (tgt == TGT_NONE);
endmodule

// File: rtl/bus_addr_decode_chk.sv
module bus_addr_decode_chk #(
  parameter int ADDR_W = 20,
  parameter int AD_W   = 16,
  localparam int HI_W  = ADDR_W - AD_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AD_W-1:0]   ad_i,
  input logic [HI_W-1:0]   a_hi_i,
  input logic              ale_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              lat_mem,
  input logic [ADDR_W-1:0] lat_addr_o,
  input logic              cs_ram_o,
  input logic              cs_mmio_o,
  input logic              cs_rom_o,
  input logic              cs_port_o,
  input logic              nodec_o
);
  p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_i |=> lat_addr_o == $past({a_hi_i, ad_i}));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_i |=> $stable(lat_addr_o) && $stable(lat_mem));

  p_mem_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ram_o || cs_mmio_o || cs_rom_o) |-> lat_mem);

  p_port_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_port_o |-> !lat_mem);

  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |-> !(cs_ram_o || cs_mmio_o || cs_rom_o || cs_port_o || nodec_o));

  p_exclusive_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cs_ram_o, cs_mmio_o, cs_rom_o, cs_port_o, nodec_o}));
endmodule

bind bus_addr_decode bus_addr_decode_chk #(.ADDR_W(ADDR_W), .AD_W(AD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ad_i       (ad_i),
  .a_hi_i     (a_hi_i),
  .ale_i      (ale_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .lat_mem    (lat_mem),
  .lat_addr_o (lat_addr_o),
  .cs_ram_o   (cs_ram_o),
  .cs_mmio_o  (cs_mmio_o),
  .cs_rom_o   (cs_rom_o),
  .cs_port_o  (cs_port_o),
  .nodec_o    (nodec_o)
);

// File: tb/test_bus_addr_decode.sv
module test_bus_addr_decode;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ad;
  logic [3:0]  a_hi;
  logic        ale, mio, rd, wr;
  logic [19:0] lat_addr;
  logic        cs_ram, cs_mmio, cs_rom, cs_port, nodec;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bus_addr_decode i_bus_addr_decode (
    .clk_i(clk), .rst_ni(rst_n), .ad_i(ad), .a_hi_i(a_hi), .ale_i(ale),
    .mio_i(mio), .rd_i(rd), .wr_i(wr), .lat_addr_o(lat_addr),
    .cs_ram_o(cs_ram), .cs_mmio_o(cs_mmio), .cs_rom_o(cs_rom),
    .cs_port_o(cs_port), .nodec_o(nodec)
  );

  // {ram, mmio, rom, port, err} expected from the memory and port maps
  function automatic logic [4:0] expect_sel(bit is_mem, logic [19:0] a);
    if (is_mem) begin
      if (a < 20'hA0000)      return 5'b10000;
      else if (a < 20'hC0000) return 5'b01000;
      else if (a < 20'hF0000) return 5'b00001;
      else                    return 5'b00100;
    end
    return (a[15:8] == 8'h00) ? 5'b00010 : 5'b00001;
  endfunction

  function automatic logic [4:0] sel_now();
    return {cs_ram, cs_mmio, cs_rom, cs_port, nodec};
  endfunction

  task automatic check(string req, logic [19:0] act, logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle: strobe, then read or write; checks latch, selects, idle
  task automatic bus_cycle(string req, bit is_mem, logic [19:0] a, bit use_wr);
    @(negedge clk);
    ale = 1'b1; ad = a[15:0]; a_hi = a[19:16]; mio = is_mem;
    @(negedge clk);
    ale = 1'b0; ad = 16'h5A5A; a_hi = ~a[19:16];
    check({req, " latch (R1)"}, lat_addr, a);
    if (use_wr) wr = 1'b1; else rd = 1'b1;
    #1;
    check({req, " select"}, {15'd0, sel_now()}, {15'd0, expect_sel(is_mem, a)});
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    #1;
    check({req, " idle (R11)"}, {15'd0, sel_now()}, 20'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ale = 1'b0; ad = 16'hFFFF; a_hi = 4'hF; mio = 1'b1;
    rd = 1'b1; wr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 reset addr", lat_addr, 20'd0);
    check("R3 reset selects", {15'd0, sel_now()}, 20'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 no select before first strobe", {15'd0, sel_now()}, 20'd0);
    rd = 1'b0;
  endtask

  task automatic t_memory_map();
    bus_cycle("R4 ram low",   1'b1, 20'h00000, 1'b0);
    bus_cycle("R4 ram top",   1'b1, 20'h9FFFF, 1'b1);
    bus_cycle("R5 mmio low",  1'b1, 20'hA0000, 1'b0);
    bus_cycle("R5 mmio top",  1'b1, 20'hBFFFF, 1'b1);
    bus_cycle("R7 gap low",   1'b1, 20'hC0000, 1'b0);
    bus_cycle("R7 gap top",   1'b1, 20'hEFFFF, 1'b0);
    bus_cycle("R6 rom low",   1'b1, 20'hF0000, 1'b0);
    bus_cycle("R6 rom top",   1'b1, 20'hFFFFF, 1'b1);
  endtask

  task automatic t_port_map();
    bus_cycle("R8 port 0",        1'b0, 20'h00000, 1'b0);
    bus_cycle("R8 port FF",       1'b0, 20'h000FF, 1'b1);
    bus_cycle("R8 upper ignored", 1'b0, 20'hF0050, 1'b0);
    bus_cycle("R9 port 100",      1'b0, 20'h00100, 1'b0);
    bus_cycle("R9 port FFFF",     1'b0, 20'h0FFFF, 1'b1);
  endtask

  task automatic t_space_split();
    bus_cycle("R10 io at ram addr",  1'b0, 20'h00050, 1'b0);
    check("R10 io no ram", {19'd0, cs_ram}, 20'd0);
    bus_cycle("R10 mem at port addr", 1'b1, 20'h00050, 1'b1);
    bus_cycle("R10 io at rom addr",  1'b0, 20'hFFF00, 1'b0);
  endtask

  task automatic t_hold();
    bus_cycle("R2 setup", 1'b1, 20'hA1234, 1'b0);
    @(negedge clk);
    ad = 16'h0000; a_hi = 4'h0; mio = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 hold addr", lat_addr, 20'hA1234);
    rd = 1'b1; #1;
    check("R2 hold type -> mmio", {15'd0, sel_now()}, 20'b01000);
    @(negedge clk); rd = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_memory_map();
    t_port_map();
    t_space_split();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule